// File: doc/BRIEF.md
# Periodic Tick Timer with Register Access

This block is a self-reloading down counter that produces a steady heartbeat for an operating system scheduler or for polled delays. A processor reaches it through a single-cycle synchronous register port: a two-bit word index, a write strobe with write data, and a read strobe. Read data is combinational, so it is valid in the same cycle as the read strobe. Each access completes in one cycle and cannot be stalled, so the port has no back-pressure.

The counter decrements on a count tick. It takes a tick either on every core clock or once every four core clocks, using a free-running two-bit prescaler. When the count reaches zero, it reloads from the reload register on the next tick. Reaching zero by counting down also does two things: it sets a sticky wrap flag that software clears by reading the control word, and, if the interrupt enable is set, it drives a one-clock request pulse to an external interrupt controller. A fixed calibration word reports the reload value for a ten-millisecond period. That value is set by a parameter.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word, reload register and count all read zero, and `irq` is low.
- R2: The word index selects the register: 0 is control/status, 1 is reload, 2 is current count, 3 is calibration. The calibration word returns parameter `CAL_VALUE` in bits 23:0 and zero above, and writes to it have no effect.
- R3: In the control word, bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the clock source, and bit 16 is the wrap flag. Bit 16 cannot be written. Every other bit reads zero.
- R4: With clock source 1 the counter takes a tick on every clock. With clock source 0 it takes a tick only on the clock edges whose index since reset release is a multiple of four, where the first edge after release is edge 1.
- R5: On a tick, a count of zero loads the reload value, and any other count decrements by one. A reload value N gives a period of N+1 ticks, and after enabling from a count of zero the first wrap comes N+1 ticks later.
- R6: The wrap flag is set when a tick moves the count from 1 to 0, and it is cleared by a read of the control word. If the read and the setting tick fall on the same clock, the read returns the old flag and the flag ends up set.
- R7: A write of any value to the current-count register zeroes the count and clears the flag in that clock. This takes priority over a tick in the same clock, and it raises no interrupt.
- R8: When the reload register holds zero, the counter stays at zero once it gets there.
- R9: `irq` is high for exactly one clock, in the clock after a tick moves the count from 1 to 0, and only if the interrupt enable bit is 1.
- R10: While the enable bit is 0, the count holds its value.
- R11: The reload and count registers keep bits 23:0 only. Written upper bits are dropped and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word index of the accessed register |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a control-word read clears the flag at the edge |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd`, zero otherwise |
| irq | output | 1 | One-clock interrupt request pulse |

## Verification
The bench sweeps reload values on both clock sources and times the first wrap and the steady period arithmetically. A counter that is off by one in its reload handling gives N or N+2 periods. A prescaler with the wrong phase places request pulses on edges that are not multiples of four. The bench lines up a control-word read with the edge that sets the flag, so a design that lets the clear win loses a wrap event. It also writes the count register exactly on the edge that would wrap, to catch a design that still fires the interrupt. Further cases are a zero reload during a run, which must park the counter, and disabling mid-count, which must freeze it.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_CALIB   = 2'd3
  } reg_sel_e;

  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int PRE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + PRE_W'(1);
  end

  assign strobe = &pre;
endmodule

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wdata,
  output logic             en,
  output logic             ie,
  output logic             src,
  output logic [CNT_W-1:0] reload
);
  import tick_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      ie  <= 1'b0;
      src <= 1'b0;
    end else if (wr_ctrl) begin
      en  <= wdata[BIT_EN];
      ie  <= wdata[BIT_IE];
      src <= wdata[BIT_SRC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload <= '0;
    else if (wr_reload) reload <= wdata;
  end

  // R3: the control fields only change on a control-word write
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(en) && $stable(ie) && $stable(src)));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ie,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] reload,
  input  logic             clr,
  input  logic             flag_rd,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             irq
);
  logic step;
  logic wrap;

  assign step = en && tick_en;
  assign wrap = step && (count == CNT_W'(1)) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (step) count <= (count == '0) ? reload : count - CNT_W'(1);
  end

  // set wins over a same-cycle read clear; a count write clears everything
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (clr)     flag <= 1'b0;
    else if (wrap)    flag <= 1'b1;
    else if (flag_rd) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wrap && ie;
  end

  assert_irq_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0) && flag);
  assert_count_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !flag && !irq);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_rd && !clr) |=> flag);
  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (count == '0));
  assert_reload_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == '0 && !clr) |=> count == $past(reload));
  assert_zero_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0 && count == '0) |=> count == '0);
  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(count));
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int          CNT_W     = 24,
  parameter int          DATA_W    = 32,
  parameter int          PRE_W     = 2,
  parameter logic [23:0] CAL_VALUE = 24'd2499
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import tick_pkg::*;

  localparam int PAD_W = DATA_W - CNT_W;

  reg_sel_e         sel;
  logic             en, ie, src, strobe, tick_en, flag;
  logic [CNT_W-1:0] reload, count;
  logic             wr_ctrl, wr_reload, wr_count, rd_ctrl;
  logic             unused_wdata_hi;

  assign sel       = reg_sel_e'(bus_addr);
  assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
  assign wr_reload = bus_wr && (sel == SEL_RELOAD);
  assign wr_count  = bus_wr && (sel == SEL_CURRENT);
  assign rd_ctrl   = bus_rd && (sel == SEL_CTRL);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  tick_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .strobe(strobe)
  );

  assign tick_en = src ? 1'b1 : strobe;

  tick_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_reload(wr_reload),
    .wdata(bus_wdata[CNT_W-1:0]), .en(en), .ie(ie), .src(src), .reload(reload)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .ie(ie), .tick_en(tick_en),
    .reload(reload), .clr(wr_count), .flag_rd(rd_ctrl),
    .count(count), .flag(flag), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_CTRL: begin
          bus_rdata[BIT_EN]   = en;
          bus_rdata[BIT_IE]   = ie;
          bus_rdata[BIT_SRC]  = src;
          bus_rdata[BIT_FLAG] = flag;
        end
        SEL_RELOAD:  bus_rdata = {{PAD_W{1'b0}}, reload};
        SEL_CURRENT: bus_rdata = {{PAD_W{1'b0}}, count};
        SEL_CALIB:   bus_rdata = {{PAD_W{1'b0}}, CAL_VALUE[CNT_W-1:0]};
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R4: on the divided source, no count change between prescaler strobes
  assert_slow_cadence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !src && !strobe && !wr_count) |=> $stable(count));
  // R11: upper bits of the count and reload never show up on the bus
  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel != SEL_CTRL) |-> bus_rdata[DATA_W-1:CNT_W] == '0);
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam logic [23:0] CAL = 24'h01E847;
  localparam logic [1:0] A_CTRL = 2'd0, A_RLD = 2'd1, A_CUR = 2'd2, A_CAL = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  tick_timer #(.CAL_VALUE(CAL)) u_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // read within the current cycle, not held across an edge: no side effect
  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic setup(input logic [31:0] n, input logic [31:0] ctrl);
    wr(A_CTRL, 32'h0); wr(A_RLD, n); wr(A_CUR, 32'h0); wr(A_CTRL, ctrl);
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!irq && k < 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k;
    int fast_n[6] = '{1, 2, 3, 5, 8, 13};
    int slow_n[4] = '{1, 2, 3, 6};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 map
    peek(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    peek(A_RLD, d);  chk("R1 reload", d, 32'h0);
    peek(A_CUR, d);  chk("R1 count", d, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    peek(A_CAL, d);  chk("R2 calib", d, {8'h0, CAL});
    wr(A_CAL, 32'h0); peek(A_CAL, d); chk("R2 calib write ignored", d, {8'h0, CAL});
    wr(A_RLD, 32'hFFFF_FFFF); peek(A_RLD, d); chk("R11 reload upper", d, 32'h00FF_FFFF);
    wr(A_RLD, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF); peek(A_CTRL, d); chk("R3 ctrl bits", d, 32'h7);
    wr(A_CTRL, 32'h0);
    wr(A_CUR, 32'hFFFF_FFFF); peek(A_CUR, d); chk("R11 count write", d, 32'h0);

    // R5/R9 fast source sweep
    foreach (fast_n[i]) begin
      setup(fast_n[i], 32'h7);
      wait_irq(k); chk("R5 first wrap", k, fast_n[i] + 1);
      @(negedge clk); chk("R9 pulse width", {31'h0, irq}, 32'h0);
      wait_irq(k); chk("R5 period fast", k + 1, fast_n[i] + 1);
    end
    setup(32'h3FF, 32'h7);
    wait_irq(k); wait_irq(k); chk("R5 period 0x3FF", k, 1024);

    // R4 divided source sweep
    foreach (slow_n[i]) begin
      setup(slow_n[i], 32'h3);
      wait_irq(k); chk("R4 edge phase", cyc % 4, 0);
      @(negedge clk); chk("R9 pulse width slow", {31'h0, irq}, 32'h0);
      wait_irq(k); chk("R4 period slow", k + 1, 4 * (slow_n[i] + 1));
      chk("R4 edge phase 2", cyc % 4, 0);
    end

    // R5 count sequence
    setup(10, 32'h5);
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk); peek(A_CUR, d);
      chk("R5 count value", d, (j <= 11) ? 32'(11 - j) : 32'd10);
    end

    // R6 flag set/clear and same-cycle read, R9 no irq when disabled
    setup(3, 32'h5);
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk); chk("R9 no irq with ie=0", {31'h0, irq}, 32'h0);
    end
    @(negedge clk); bus_addr = A_CTRL; bus_rd = 1'b1; #1;
    chk("R6 flag set", bus_rdata, 32'h0001_0005);
    @(negedge clk); #1;
    chk("R6 flag cleared by read", bus_rdata, 32'h5);
    @(negedge clk); bus_rd = 1'b0;
    peek(A_CTRL, d); chk("R6 set wins over read", d, 32'h0001_0005);

    // R7 count write on the wrapping edge
    setup(3, 32'h7);
    repeat (3) @(negedge clk);
    bus_addr = A_CUR; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R7 no irq", {31'h0, irq}, 32'h0);
    peek(A_CUR, d);  chk("R7 count zero", d, 32'h0);
    peek(A_CTRL, d); chk("R7 flag clear", d, 32'h7);
    @(negedge clk); peek(A_CUR, d); chk("R7 reload after", d, 32'd3);
    wait_irq(k); chk("R7 resumes", k, 3);

    // R8 zero reload
    setup(0, 32'h7);
    repeat (20) @(negedge clk);
    peek(A_CUR, d); chk("R8 idle zero", d, 32'h0);
    chk("R8 no irq", {31'h0, irq}, 32'h0);
    setup(4, 32'h7);
    wr(A_RLD, 32'h0);
    wait_irq(k); chk("R8 last wrap", k, 3);
    repeat (10) @(negedge clk);
    peek(A_CUR, d); chk("R8 parked", d, 32'h0);
    chk("R8 no further irq", {31'h0, irq}, 32'h0);

    // R10 disable freezes
    setup(20, 32'h7);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h4);
    peek(A_CUR, d); chk("R10 frozen value", d, 32'd14);
    repeat (8) @(negedge clk);
    peek(A_CUR, d); chk("R10 still frozen", d, 32'd14);
    wr(A_CTRL, 32'h7);
    @(negedge clk); peek(A_CUR, d); chk("R10 resumes", d, 32'd13);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule